// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block turns a stream of raw readings from one sensor into filtered results. A 3-bit mode code picks the filter. It can pass each reading straight through, average a pair of readings, or collect a group of readings, drop the single smallest and the single largest, and average the rest. The count that is averaged is always a power of two, so the division is a right shift.

Each reading arrives with a one-cycle valid strobe. Each finished result leaves on a one-cycle valid strobe, in the cycle after the reading that completes its group. Readings may come back to back or with idle cycles between them. An immediate input bypasses the filter and returns the current reading at once. It also drops any partly collected group. The mode is sampled on the first reading of each group and then held until that group completes.

Top module: `trim_mean_filter`

## Requirements
- R1: After reset `res_valid_o` and `res_data_o` are 0, and the first reading accepted after reset starts a new group.
- R2: In mode 3'b000 every reading with `immed_i` low produces a result equal to that reading.
- R3: Mode 3'b001 collects 2 readings and returns floor((a+b)/2).
- R4: Mode 3'b010 collects 4 readings, removes one minimum and one maximum, and returns floor(rest/2).
- R5: Mode 3'b011 collects 6 readings, removes one minimum and one maximum, and returns floor(rest/4).
- R6: Mode 3'b100 collects 10 readings, removes one minimum and one maximum, and returns floor(rest/8).
- R7: Mode 3'b101 collects 18 readings, removes one minimum and one maximum, and returns floor(rest/16). There is no overflow when every reading is all ones.
- R8: Mode codes 3'b110 and 3'b111 behave exactly like 3'b000.
- R9: A reading with `immed_i` high is returned unchanged in the next cycle, whatever the mode. Any partly collected group is discarded, so the next normal reading starts a new group.
- R10: A change of `mode_i` in the middle of a group has no effect until that group has completed.
- R11: `res_valid_o` is high for exactly one cycle, in the cycle after the reading that completes a group (or after an immediate reading), and at no other time. Idle cycles between readings do not advance a group.

Readings are unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Filter mode code |
| immed_i | input | 1 | Bypass the filter for this reading |
| smp_valid_i | input | 1 | Reading strobe |
| smp_data_i | input | DATA_W | Raw reading |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | DATA_W | Filtered result |

## Verification
A wrong group counter moves the result strobe earlier or later than the reading that should close the group. The first group in any multi-sample mode exposes this, within at most 18 readings. A wrong minimum, maximum or running sum does not disturb the strobe, but the result value of the same group comes out wrong. The bench chooses readings so that removing the wrong sample changes the mean. Errors in latching the mode, or in discarding a partial group on an immediate reading, appear as a misplaced strobe or a wrong value in the group that follows the mode change or the bypassed reading.

// File: rtl/tmf_pkg.sv
`timescale 1ns/1ps
package tmf_pkg;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned MAX_LEN = 18;

  // readings gathered per result
  function automatic logic [31:0] grp_len(input logic [MODE_W-1:0] m);
    case (m)
      3'd1:    return 32'd2;
      3'd2:    return 32'd4;
      3'd3:    return 32'd6;
      3'd4:    return 32'd10;
      3'd5:    return 32'd18;
      default: return 32'd1;
    endcase
  endfunction

  // log2 of the count that is averaged
  function automatic logic [31:0] grp_shift(input logic [MODE_W-1:0] m);
    case (m)
      3'd1, 3'd2: return 32'd1;
      3'd3:       return 32'd2;
      3'd4:       return 32'd3;
      3'd5:       return 32'd4;
      default:    return 32'd0;
    endcase
  endfunction

  function automatic logic grp_trim(input logic [MODE_W-1:0] m);
    return m inside {3'd2, 3'd3, 3'd4, 3'd5};
  endfunction

  function automatic logic [31:0] trimmed_mean(input logic [31:0] s, input logic [31:0] mn,
                                               input logic [31:0] mx, input logic [MODE_W-1:0] m);
    logic [31:0] r;
    r = grp_trim(m) ? (s - mn - mx) : s;
    return r >> grp_shift(m);
  endfunction
endpackage

// File: rtl/tmf_seq.sv
`timescale 1ns/1ps
module tmf_seq
  import tmf_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flush,
  input  logic [MODE_W-1:0] mode_i,
  output logic              first,
  output logic              last,
  output logic [MODE_W-1:0] eff_mode,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] mode_q;

  assign first    = (cnt_q == '0);
  assign eff_mode = first ? mode_i : mode_q;
  assign last     = ((32'(cnt_q) + 32'd1) == grp_len(eff_mode));
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (first) mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/tmf_extrema.sv
`timescale 1ns/1ps
module tmf_extrema #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         first,
  input  logic [W-1:0] d,
  output logic [W-1:0] mn_nx,
  output logic [W-1:0] mx_nx
);
  logic [W-1:0] mn_q, mx_q;

  always_comb begin
    mn_nx = (first || d < mn_q) ? d : mn_q;
    mx_nx = (first || d > mx_q) ? d : mx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mn_q <= '0;
      mx_q <= '0;
    end else if (take) begin
      mn_q <= mn_nx;
      mx_q <= mx_nx;
    end
  end
endmodule

// File: rtl/tmf_accum.sv
`timescale 1ns/1ps
module tmf_accum #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          first,
  input  logic [W-1:0]  d,
  output logic [SW-1:0] sum_nx
);
  logic [SW-1:0] sum_q;

  assign sum_nx = (first ? '0 : sum_q) + SW'(d);

  always_ff @(posedge clk) begin
    if (!rst_n)    sum_q <= '0;
    else if (take) sum_q <= sum_nx;
  end
endmodule

// File: rtl/trim_mean_filter.sv
`timescale 1ns/1ps
module trim_mean_filter
  import tmf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              immed_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN);
  localparam int unsigned SUM_W = DATA_W + CNT_W;

  logic              take, flush, grp_first, grp_last, grp_done;
  logic [MODE_W-1:0] eff_mode;
  logic [CNT_W-1:0]  seq_cnt;
  logic [DATA_W-1:0] mn_nx, mx_nx, res_nx;
  logic [SUM_W-1:0]  sum_nx;
  logic              res_valid_q;
  logic [DATA_W-1:0] res_q;

  assign take     = smp_valid_i & ~immed_i;
  assign flush    = smp_valid_i & immed_i;
  assign grp_done = take & grp_last;

  tmf_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .mode_i(mode_i),
    .first(grp_first), .last(grp_last), .eff_mode(eff_mode), .cnt(seq_cnt)
  );

  tmf_extrema #(.W(DATA_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .take(take), .first(grp_first), .d(smp_data_i),
    .mn_nx(mn_nx), .mx_nx(mx_nx)
  );

  tmf_accum #(.W(DATA_W), .SW(SUM_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(grp_first), .d(smp_data_i),
    .sum_nx(sum_nx)
  );

  assign res_nx = DATA_W'(trimmed_mean(32'(sum_nx), 32'(mn_nx), 32'(mx_nx), eff_mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= grp_done | flush;
      if (flush)         res_q <= smp_data_i;
      else if (grp_done) res_q <= res_nx;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_q;
endmodule

// File: rtl/tmf_checker.sv
`timescale 1ns/1ps
module tmf_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic              immed_i,
  input logic              smp_valid_i,
  input logic [DATA_W-1:0] smp_data_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              grp_first,
  input logic              grp_last,
  input logic [2:0]        eff_mode,
  input logic [CNT_W-1:0]  seq_cnt
);
  assert_result_after_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(smp_valid_i));

  assert_no_early_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !immed_i && !grp_last) |=> !res_valid_o);

  assert_immediate_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && immed_i) |=> (res_valid_o && res_data_o == $past(smp_data_i)));

  assert_single_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !immed_i && grp_first && mode_i == 3'b000)
      |=> (res_valid_o && res_data_o == $past(smp_data_i)));

  assert_spare_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !immed_i && grp_first && mode_i[2:1] == 2'b11)
      |=> (res_valid_o && res_data_o == $past(smp_data_i)));

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_first && $past(!grp_first)) |-> $stable(eff_mode));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cnt < CNT_W'(18));
endmodule

bind trim_mean_filter tmf_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .immed_i(immed_i),
  .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
  .res_valid_o(res_valid_o), .res_data_o(res_data_o),
  .grp_first(grp_first), .grp_last(grp_last), .eff_mode(eff_mode), .seq_cnt(seq_cnt)
);

// File: tb/trim_mean_filter_test.sv
`timescale 1ns/1ps
module trim_mean_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        immed_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = 16'd0;
  logic        res_valid_o;
  logic [15:0] res_data_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  trim_mean_filter #(.DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .immed_i(immed_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one reading at a falling edge, sample the outputs at the next falling edge
  task automatic push(input logic [15:0] d, input logic imm, output logic v, output logic [15:0] q);
    smp_data_i = d; immed_i = imm; smp_valid_i = 1'b1;
    @(negedge clk);
    v = res_valid_o; q = res_data_o;
    smp_valid_i = 1'b0; immed_i = 1'b0;
  endtask

  // reference: drop one min and one max by index, divide the rest by count
  function automatic longint ref_mean(input longint vals[18], input int n);
    longint s = 0;
    int imn = 0, imx = n - 1;
    if (n <= 2) begin
      for (int i = 0; i < n; i++) s += vals[i];
      return s / n;
    end
    for (int i = 0; i < n; i++) if (vals[i] < vals[imn]) imn = i;
    for (int i = n - 1; i >= 0; i--) if (vals[i] > vals[imx]) imx = i;
    for (int i = 0; i < n; i++) if (i != imn && i != imx) s += vals[i];
    return s / (n - 2);
  endfunction

  task automatic run_group(input logic [2:0] m, input int n, input longint vals[18], input string req);
    logic v; logic [15:0] q;
    longint exp = ref_mean(vals, n);
    mode_i = m;
    for (int i = 0; i < n; i++) begin
      push(16'(vals[i]), 1'b0, v, q);
      if (i < n - 1) check(v == 1'b0, {req, " early strobe"}, longint'(v), 0);
      else begin
        check(v == 1'b1, {req, " strobe"}, longint'(v), 1);
        check(q == 16'(exp), {req, " value"}, longint'(q), exp);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(res_valid_o == 1'b0, "R1 valid after reset", longint'(res_valid_o), 0);
    check(res_data_o == 16'd0, "R1 data after reset", longint'(res_data_o), 0);
  endtask

  task automatic t_modes(input int seed);
    longint vals[18];
    int lens[6] = '{1, 2, 4, 6, 10, 18};
    string reqs[6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};
    for (int m = 0; m < 6; m++) begin
      for (int i = 0; i < 18; i++) vals[i] = longint'(((seed + 1) * 7919 + i * 40503 + m * 311) % 65536);
      run_group(3'(m), lens[m], vals, reqs[m]);
    end
  endtask

  task automatic t_extremes;
    longint vals[18];
    for (int i = 0; i < 18; i++) vals[i] = 65535;
    vals[5] = 0;
    run_group(3'd5, 18, vals, "R7 all-ones");
    for (int i = 0; i < 18; i++) vals[i] = (i % 2 == 0) ? 100 : 9;
    vals[3] = 60000; vals[7] = 1;
    run_group(3'd4, 10, vals, "R6 outliers");
    for (int i = 0; i < 18; i++) vals[i] = 500;
    run_group(3'd2, 4, vals, "R4 equal");
    vals[0] = 7; vals[1] = 8;
    run_group(3'd1, 2, vals, "R3 floor");
  endtask

  task automatic t_spare;
    logic v; logic [15:0] q;
    mode_i = 3'b110;
    push(16'd1234, 1'b0, v, q);
    check(v && q == 16'd1234, "R8 code 110", longint'(q), 1234);
    mode_i = 3'b111;
    push(16'd4321, 1'b0, v, q);
    check(v && q == 16'd4321, "R8 code 111", longint'(q), 4321);
  endtask

  task automatic t_immediate;
    logic v; logic [15:0] q;
    mode_i = 3'd3;
    push(16'd10, 1'b0, v, q);
    push(16'd20, 1'b0, v, q);
    push(16'd30, 1'b0, v, q);
    push(16'd999, 1'b1, v, q);
    check(v && q == 16'd999, "R9 bypass value", longint'(q), 999);
    mode_i = 3'd1;
    push(16'd40, 1'b0, v, q);
    check(v == 1'b0, "R9 new group not done", longint'(v), 0);
    push(16'd51, 1'b0, v, q);
    check(v && q == 16'd45, "R9 partial dropped", longint'(q), 45);
  endtask

  task automatic t_mode_switch;
    logic v; logic [15:0] q;
    mode_i = 3'd2;
    push(16'd100, 1'b0, v, q);
    push(16'd1, 1'b0, v, q);
    mode_i = 3'd0;
    push(16'd300, 1'b0, v, q);
    check(v == 1'b0, "R10 mode held", longint'(v), 0);
    push(16'd900, 1'b0, v, q);
    check(v && q == 16'd200, "R10 held result", longint'(q), 200);
    push(16'd77, 1'b0, v, q);
    check(v && q == 16'd77, "R10 new mode applies", longint'(q), 77);
  endtask

  task automatic t_gaps;
    logic v; logic [15:0] q;
    mode_i = 3'd1;
    push(16'd1000, 1'b0, v, q);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(res_valid_o == 1'b0, "R11 idle", longint'(res_valid_o), 0);
    end
    push(16'd3001, 1'b0, v, q);
    check(v && q == 16'd2000, "R11 gap group", longint'(q), 2000);
    @(negedge clk);
    check(res_valid_o == 1'b0, "R11 single pulse", longint'(res_valid_o), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_modes(1);
    t_modes(42);
    t_extremes();
    t_spare();
    t_immediate();
    t_mode_switch();
    t_gaps();
    t_reset();
    mode_i = 3'd1;
    t_modes(7);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule